// File: doc/BRIEF.md
# Callee-Saved Register Stack Save/Restore Sequencer

This block carries out compressed stack-frame save and restore operations. A single decoded request names an operation (save, restore, restore-and-return, restore-and-return with a zeroed result register), a 4-bit list code, a pre-scaled extra frame offset, and the data width for the operation. The list code selects a contiguous set of callee-saved registers. The block then walks that set one register per cycle, starting with the highest-numbered register. For each register it issues a load or store over a simple memory request port and reads or writes the register file to match.

When the last transfer has been accepted, the block writes the new stack pointer and pulses `done`. For the return variants it also redirects the PC to the return address that it has just restored. The zeroing variant additionally clears x10 in that same cycle.

A list code that cannot be honoured raises `illegal` for one cycle and does nothing else. The memory port is a single-cycle handshake: the request is held until `mem_ready` is high, and load data is taken in the same cycle.

Top module: `regsave_sequencer`

## Requirements
- R1: List code 4 selects x1 only. Code 5 adds x8, code 6 adds x9, and each code from 7 to 14 adds one more register in turn from x18 to x25. Code 15 selects x1, x8, x9 and x18 through x27 (13 registers). Transfers run from the highest-numbered selected register down to x1.
- R2: When `cfg_reduced` is high, list codes 7 to 15 are illegal. Codes 4 to 6 stay legal.
- R3: A request with list code 0 to 3, or one made illegal by R2, raises `illegal` for exactly the one cycle after acceptance. It produces no memory request, no register-file write, no SP or PC write, and `busy` stays low.
- R4: The frame size equals the register count times the register size, rounded up to a multiple of 16, plus `req_imm` (a multiple of 16 from 0 to 48).
- R5: A save (`req_op`=0) issues stores (`mem_write`=1). The first store goes to SP minus one register size, and each following store goes one register size lower. The store data is `rf_rdata` for the register presented on `rf_raddr`.
- R6: A restore (`req_op`=1, 2 or 3) issues loads (`mem_write`=0). The first load comes from SP plus the frame size minus one register size, and each following load comes one register size lower. Each accepted load writes `mem_rdata` to that register through `rf_we`/`rf_waddr`/`rf_wdata`.
- R7: One cycle after the last transfer is accepted, `sp_we` and `done` are high for one cycle. `sp_wdata` is then SP minus the frame for a save and SP plus the frame for a restore.
- R8: In that final cycle, `req_op`=2 or 3 raises `pc_we` with `pc_wdata` equal to the value just loaded into x1. `req_op`=3 also writes 0 to x10 in that cycle.
- R9: `busy` is high from the cycle after acceptance through the cycle of the SP write. Requests presented while `busy` is high are ignored.
- R10: With `req_wide`=1 the register size is 8 bytes and `mem_dbl`=1. With `req_wide`=0 the register size is 4 bytes, `mem_dbl`=0, and addresses, SP, store data and loaded data are truncated to their low 32 bits.
- R11: While `mem_ready` is low, the memory request holds its address, no register-file write occurs, and the sequence does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 save, 1 restore, 2 restore+return, 3 restore+return+zero |
| req_list | input | 4 | Register list code |
| req_imm | input | IMM_W | Extra frame bytes, multiple of 16 |
| req_wide | input | 1 | 1 = 8-byte registers, 0 = 4-byte registers |
| cfg_reduced | input | 1 | Reduced register file configuration |
| sp_in | input | XLEN | Current stack pointer |
| busy | output | 1 | Sequence in progress |
| illegal | output | 1 | Illegal request pulse |
| mem_valid | output | 1 | Memory request |
| mem_write | output | 1 | 1 store, 0 load |
| mem_dbl | output | 1 | 1 = 8-byte access, 0 = 4-byte access |
| mem_addr | output | XLEN | Access address |
| mem_wdata | output | XLEN | Store data |
| mem_ready | input | 1 | Memory accepts request this cycle |
| mem_rdata | input | XLEN | Load data, valid with mem_ready |
| rf_raddr | output | RF_AW | Register-file read index |
| rf_rdata | input | XLEN | Register-file read data |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | RF_AW | Register-file write index |
| rf_wdata | output | XLEN | Register-file write data |
| sp_we | output | 1 | Stack pointer write |
| sp_wdata | output | XLEN | New stack pointer |
| pc_we | output | 1 | PC redirect |
| pc_wdata | output | XLEN | Return target |
| done | output | 1 | Sequence complete pulse |

## Verification
The embedded assertions check the cycle-level properties on every clock. A stalled request keeps its address. Consecutive accepted transfers step down by one register size. A PC redirect always coincides with an SP write. `done` is always followed by an idle cycle. `busy` only rises after a request. An illegal pulse never carries a transfer.

The exact register order for each list code, the frame arithmetic, the start addresses, and the value restored into the PC can only be shown by the bench. It runs a behavioural model over save and restore sequences of several lengths, in both widths, with the reduced configuration, with stalls, and with requests presented while busy.

// File: rtl/regsave_pkg.sv
package regsave_pkg;

   typedef enum logic [1:0] {
      OP_SAVE      = 2'd0,
      OP_LOAD      = 2'd1,
      OP_LOAD_RET  = 2'd2,
      OP_LOAD_RETZ = 2'd3
   } seq_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_XFER = 2'd1,
      ST_FIN  = 2'd2
   } seq_state_e;

   localparam logic [4:0] REG_RA  = 5'd1;
   localparam logic [4:0] REG_RES = 5'd10;

   // slot 0 is the return address, slot 1..2 are x8/x9, slot 3.. map to x18 upward
   function automatic logic [4:0] slot_reg(input logic [3:0] slot);
      logic [4:0] r;
      case (slot)
         4'd0:    r = 5'd1;
         4'd1:    r = 5'd8;
         4'd2:    r = 5'd9;
         default: r = {1'b0, slot} + 5'd15;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/regsave_list_decode.sv
module regsave_list_decode #(
   parameter int CODE_W = 4,
   parameter int CNT_W  = 4
) (
   input  logic [CODE_W-1:0] list_code,
   input  logic              reduced,
   output logic              legal,
   output logic [CNT_W-1:0]  count
);
   localparam logic [CODE_W-1:0] FIRST_OK   = CODE_W'(4);
   localparam logic [CODE_W-1:0] REDUCED_MX = CODE_W'(6);
   localparam logic [CODE_W-1:0] TOP_CODE   = CODE_W'(15);

   if (CODE_W != 4) begin : g_bad_code
      $error("regsave_list_decode: CODE_W must be 4");
   end

   always_comb begin
      legal = (list_code >= FIRST_OK) && !(reduced && (list_code > REDUCED_MX));
      if (list_code == TOP_CODE)
         count = CNT_W'(13);
      else
         count = CNT_W'(list_code) - CNT_W'(3);
   end
endmodule

// File: rtl/regsave_frame_calc.sv
module regsave_frame_calc #(
   parameter int CNT_W   = 4,
   parameter int IMM_W   = 6,
   parameter int FRAME_W = 8
) (
   input  logic [CNT_W-1:0]   count,
   input  logic               wide,
   input  logic [IMM_W-1:0]   imm,
   output logic [FRAME_W-1:0] frame
);
   localparam logic [FRAME_W-1:0] ALIGN_M = FRAME_W'(15);

   if (FRAME_W < CNT_W + 5) begin : g_bad_frame
      $error("regsave_frame_calc: FRAME_W too narrow");
   end

   logic [FRAME_W-1:0] raw_bytes;
   logic [FRAME_W-1:0] aligned;

   always_comb begin
      raw_bytes = wide ? (FRAME_W'(count) << 3) : (FRAME_W'(count) << 2);
      aligned   = (raw_bytes + ALIGN_M) & ~ALIGN_M;
      frame     = aligned + FRAME_W'(imm);
   end
endmodule

// File: rtl/regsave_sequencer.sv
module regsave_sequencer
   import regsave_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int RF_AW = 5,
   parameter int IMM_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [1:0]       req_op,
   input  logic [3:0]       req_list,
   input  logic [IMM_W-1:0] req_imm,
   input  logic             req_wide,
   input  logic             cfg_reduced,
   input  logic [XLEN-1:0]  sp_in,
   output logic             busy,
   output logic             illegal,
   output logic             mem_valid,
   output logic             mem_write,
   output logic             mem_dbl,
   output logic [XLEN-1:0]  mem_addr,
   output logic [XLEN-1:0]  mem_wdata,
   input  logic             mem_ready,
   input  logic [XLEN-1:0]  mem_rdata,
   output logic [RF_AW-1:0] rf_raddr,
   input  logic [XLEN-1:0]  rf_rdata,
   output logic             rf_we,
   output logic [RF_AW-1:0] rf_waddr,
   output logic [XLEN-1:0]  rf_wdata,
   output logic             sp_we,
   output logic [XLEN-1:0]  sp_wdata,
   output logic             pc_we,
   output logic [XLEN-1:0]  pc_wdata,
   output logic             done
);
   localparam int CNT_W   = 4;
   localparam int FRAME_W = IMM_W + 3;
   localparam logic [XLEN-1:0] NARROW_M = XLEN'(64'hFFFF_FFFF);

   if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
      $error("regsave_sequencer: XLEN must be 32 or 64");
   end
   if (RF_AW < 5) begin : g_bad_aw
      $error("regsave_sequencer: RF_AW must be at least 5");
   end
   if (IMM_W < 6) begin : g_bad_imm
      $error("regsave_sequencer: IMM_W must hold 48");
   end

   // width option: only a 64-bit build can run 8-byte transfers
   logic wide_eff;
   if (XLEN == 64) begin : g_wide
      assign wide_eff = req_wide;
   end else begin : g_narrow_only
      assign wide_eff = 1'b0;
   end

   function automatic logic [XLEN-1:0] fit(input logic [XLEN-1:0] v, input logic w);
      return w ? v : (v & NARROW_M);
   endfunction

   logic               dec_legal;
   logic [CNT_W-1:0]   dec_count;
   logic [FRAME_W-1:0] calc_frame;

   regsave_list_decode #(.CODE_W(4), .CNT_W(CNT_W)) u_dec (
      .list_code (req_list),
      .reduced   (cfg_reduced),
      .legal     (dec_legal),
      .count     (dec_count)
   );

   regsave_frame_calc #(.CNT_W(CNT_W), .IMM_W(IMM_W), .FRAME_W(FRAME_W)) u_frame (
      .count (dec_count),
      .wide  (wide_eff),
      .imm   (req_imm),
      .frame (calc_frame)
   );

   seq_state_e         state_q;
   seq_op_e            op_q;
   logic               wide_q;
   logic [CNT_W-1:0]   slot_q;
   logic [XLEN-1:0]    addr_q;
   logic [XLEN-1:0]    sp_q;
   logic [FRAME_W-1:0] frame_q;
   logic [XLEN-1:0]    ra_q;
   logic               illegal_q;

   logic            accept;
   logic [XLEN-1:0] rsz_new;
   logic [XLEN-1:0] rsz_cur;
   logic [XLEN-1:0] first_addr;
   logic [4:0]      cur_reg;
   logic            xfer_go;
   logic            is_save;

   assign accept   = req_valid && (state_q == ST_IDLE);
   assign rsz_new  = wide_eff ? XLEN'(8) : XLEN'(4);
   assign rsz_cur  = wide_q ? XLEN'(8) : XLEN'(4);
   assign cur_reg  = slot_reg(slot_q);
   assign xfer_go  = (state_q == ST_XFER) && mem_ready;
   assign is_save  = (op_q == OP_SAVE);

   always_comb begin
      if (seq_op_e'(req_op) == OP_SAVE)
         first_addr = fit(sp_in - rsz_new, wide_eff);
      else
         first_addr = fit(sp_in + XLEN'(calc_frame) - rsz_new, wide_eff);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         op_q      <= OP_SAVE;
         wide_q    <= 1'b0;
         slot_q    <= '0;
         addr_q    <= '0;
         sp_q      <= '0;
         frame_q   <= '0;
         ra_q      <= '0;
         illegal_q <= 1'b0;
      end else begin
         illegal_q <= accept && !dec_legal;
         case (state_q)
            ST_IDLE: begin
               if (accept && dec_legal) begin
                  state_q <= ST_XFER;
                  op_q    <= seq_op_e'(req_op);
                  wide_q  <= wide_eff;
                  slot_q  <= dec_count - CNT_W'(1);
                  addr_q  <= first_addr;
                  sp_q    <= fit(sp_in, wide_eff);
                  frame_q <= calc_frame;
               end
            end
            ST_XFER: begin
               if (mem_ready) begin
                  if (!is_save && cur_reg == REG_RA)
                     ra_q <= fit(mem_rdata, wide_q);
                  if (slot_q == '0) begin
                     state_q <= ST_FIN;
                  end else begin
                     slot_q <= slot_q - CNT_W'(1);
                     addr_q <= fit(addr_q - rsz_cur, wide_q);
                  end
               end
            end
            ST_FIN:  state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      busy      = (state_q != ST_IDLE);
      illegal   = illegal_q;
      mem_valid = (state_q == ST_XFER);
      mem_write = is_save;
      mem_dbl   = wide_q;
      mem_addr  = addr_q;
      mem_wdata = fit(rf_rdata, wide_q);
      rf_raddr  = RF_AW'(cur_reg);
      done      = (state_q == ST_FIN);
      sp_we     = (state_q == ST_FIN);
      sp_wdata  = is_save ? fit(sp_q - XLEN'(frame_q), wide_q)
                          : fit(sp_q + XLEN'(frame_q), wide_q);
      pc_we     = (state_q == ST_FIN) && (op_q == OP_LOAD_RET || op_q == OP_LOAD_RETZ);
      pc_wdata  = ra_q;
      if (state_q == ST_FIN) begin
         rf_we    = (op_q == OP_LOAD_RETZ);
         rf_waddr = RF_AW'(REG_RES);
         rf_wdata = '0;
      end else begin
         rf_we    = xfer_go && !is_save;
         rf_waddr = RF_AW'(cur_reg);
         rf_wdata = fit(mem_rdata, wide_q);
      end
   end

   // R11: a refused request is held unchanged into the next cycle
   assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));

   // R5 / R6: accepted transfers that are not the last step one register size down
   assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_ready && !$isunknown(slot_q) && slot_q != '0) |=>
      (mem_valid && mem_addr == fit($past(mem_addr) - rsz_cur, wide_q)));

   // R8: a return redirect only happens together with the SP write
   assert_ret_with_sp_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pc_we |-> (sp_we && done));

   // R9: the cycle after completion is idle, and busy only starts on a request
   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);
   assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_valid));

   // R3: an illegal pulse carries no traffic and never follows itself without a request
   assert_illegal_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (!mem_valid && !sp_we && !pc_we && !busy));
   assert_illegal_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (illegal && !$past(req_valid)) |-> 1'b0);

   // R1: a legal list never asks for more than 13 or fewer than 1 transfer
   assert_count_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && dec_legal) |-> (dec_count >= CNT_W'(1) && dec_count <= CNT_W'(13)));

endmodule

// File: tb/sim_regsave_sequencer.sv
`timescale 1ns/1ps
module sim_regsave_sequencer;
   localparam int XLEN = 64;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic [1:0]      req_op = 2'd0;
   logic [3:0]      req_list = 4'd0;
   logic [5:0]      req_imm = 6'd0;
   logic            req_wide = 1'b0;
   logic            cfg_reduced = 1'b0;
   logic [XLEN-1:0] sp_in = '0;
   logic            busy, illegal, mem_valid, mem_write, mem_dbl;
   logic [XLEN-1:0] mem_addr, mem_wdata, mem_rdata, rf_rdata, rf_wdata;
   logic            mem_ready = 1'b1;
   logic [4:0]      rf_raddr, rf_waddr;
   logic            rf_we, sp_we, pc_we, done;
   logic [XLEN-1:0] sp_wdata, pc_wdata;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   function automatic logic [63:0] memval(input logic [63:0] a);
      return {a[31:0] ^ 32'h5A5A_0000, ~a[31:0]};
   endfunction
   function automatic logic [63:0] rfval(input logic [4:0] r);
      return {32'h1234_0000 + {27'd0, r}, 32'h9876_0000 + {27'd0, r}};
   endfunction
   function automatic int slotreg(input int s);
      if (s == 0) return 1;
      if (s == 1) return 8;
      if (s == 2) return 9;
      return s + 15;
   endfunction

   always_comb mem_rdata = memval(mem_addr);
   always_comb rf_rdata  = rfval(rf_raddr);

   regsave_sequencer #(.XLEN(XLEN), .RF_AW(5), .IMM_W(6)) u0 (
      .clk, .rst_n, .req_valid, .req_op, .req_list, .req_imm, .req_wide, .cfg_reduced,
      .sp_in, .busy, .illegal, .mem_valid, .mem_write, .mem_dbl, .mem_addr, .mem_wdata,
      .mem_ready, .mem_rdata, .rf_raddr, .rf_rdata, .rf_we, .rf_waddr, .rf_wdata,
      .sp_we, .sp_wdata, .pc_we, .pc_wdata, .done
   );

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic do_op(input int op, input int lst, input int imm, input bit wide,
                        input bit red, input logic [63:0] sp, input int stall_mod, input bit poke);
      logic [63:0] m, addr, ra_exp, sp_exp;
      int cnt, rsz, frame, cyc;
      bit legal, rdy;
      int regs[$];
      m      = wide ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
      legal  = (lst >= 4) && !(red && lst > 6);
      cnt    = (lst == 15) ? 13 : lst - 3;
      rsz    = wide ? 8 : 4;
      frame  = ((cnt * rsz + 15) / 16) * 16 + imm;
      ra_exp = '0;
      if (legal)
         for (int s = cnt - 1; s >= 0; s--) regs.push_back(slotreg(s));
      @(negedge clk);
      req_valid = 1'b1; req_op = 2'(op); req_list = 4'(lst); req_imm = 6'(imm);
      req_wide = wide; cfg_reduced = red; sp_in = sp; mem_ready = 1'b1;
      @(negedge clk);
      req_valid = legal && poke;
      if (poke) begin req_op = 2'd0; req_list = 4'd15; end
      if (!legal) begin
         chk("R3", "illegal", illegal, 1);
         chk("R3", "busy", busy, 0);
         chk("R3", "mem_valid", mem_valid, 0);
         chk("R3", "rf_we", rf_we, 0);
         chk("R3", "sp_we", sp_we, 0);
         chk(red ? "R2" : "R1", "pc_we", pc_we, 0);
         @(negedge clk);
         chk("R3", "illegal second cycle", illegal, 0);
         return;
      end
      addr = (op == 0) ? ((sp - 64'(rsz)) & m) : ((sp + 64'(frame) - 64'(rsz)) & m);
      cyc  = 0;
      while (regs.size() > 0) begin
         rdy = (stall_mod == 0) || ((cyc % stall_mod) != 1);
         cyc++;
         mem_ready = rdy;
         #1;
         chk("R9", "busy", busy, 1);
         chk("R1", "mem_valid", mem_valid, 1);
         chk((op == 0) ? "R5" : "R6", "mem_addr", mem_addr, addr);
         chk((op == 0) ? "R5" : "R6", "mem_write", mem_write, (op == 0));
         chk("R10", "mem_dbl", mem_dbl, wide);
         if (op == 0) begin
            chk("R1", "rf_raddr order", rf_raddr, 64'(regs[0]));
            chk("R5", "mem_wdata", mem_wdata, rfval(5'(regs[0])) & m);
            chk("R5", "rf_we", rf_we, 0);
         end else begin
            chk("R11", "rf_we", rf_we, rdy);
            if (rdy) begin
               chk("R1", "rf_waddr order", rf_waddr, 64'(regs[0]));
               chk("R6", "rf_wdata", rf_wdata, memval(addr) & m);
               if (regs[0] == 1) ra_exp = memval(addr) & m;
            end
         end
         if (rdy) begin
            void'(regs.pop_front());
            addr = (addr - 64'(rsz)) & m;
         end
         @(negedge clk);
      end
      sp_exp = (op == 0) ? ((sp - 64'(frame)) & m) : ((sp + 64'(frame)) & m);
      chk("R7", "sp_we", sp_we, 1);
      chk("R7", "done", done, 1);
      chk("R4", "sp_wdata", sp_wdata, sp_exp);
      chk("R9", "busy at sp write", busy, 1);
      chk("R8", "pc_we", pc_we, (op >= 2));
      if (op >= 2) chk("R8", "pc_wdata", pc_wdata, ra_exp);
      chk("R8", "zero write", rf_we, (op == 3));
      if (op == 3) begin
         chk("R8", "zero addr", rf_waddr, 10);
         chk("R8", "zero data", rf_wdata, 0);
      end
      req_valid = 1'b0;
      @(negedge clk);
      chk("R9", "busy after", busy, 0);
      chk("R9", "request while busy ignored", mem_valid, 0);
      chk("R7", "done pulse", done, 0);
   endtask

   initial begin
      #(8 * 200000);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R9", "reset busy", busy, 0);
      chk("R3", "reset illegal", illegal, 0);
      chk("R7", "reset done", done, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11", "idle mem_valid", mem_valid, 0);

      do_op(0, 4, 0, 1, 0, 64'h0000_0000_0000_1000, 0, 0);    // save x1 only
      do_op(1, 15, 48, 1, 0, 64'h0000_0000_0000_2000, 3, 0);  // restore all, stalls
      do_op(2, 6, 16, 0, 0, 64'h0000_0000_0000_0800, 0, 0);   // restore+return narrow
      do_op(3, 10, 32, 1, 0, 64'h0000_0000_0004_0000, 2, 1);  // zero variant, poke while busy
      do_op(1, 2, 0, 1, 0, 64'h0000_0000_0000_1000, 0, 0);    // code below 4 illegal
      do_op(0, 7, 0, 1, 1, 64'h0000_0000_0000_1000, 0, 0);    // R2 reduced rejects 7
      do_op(0, 6, 0, 1, 1, 64'h0000_0000_0000_1000, 0, 0);    // R2 reduced accepts 6
      do_op(0, 15, 0, 0, 0, 64'hFFFF_FFFF_0000_0100, 4, 0);   // R10 narrow truncation
      do_op(3, 4, 0, 0, 0, 64'h0000_0000_0000_0040, 0, 0);    // narrow zero return
      do_op(0, 12, 16, 1, 0, 64'h0000_0000_0000_3000, 0, 1);  // save with poke

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule